// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block holds the host-programmed state of a four-channel DMA controller in the classic style and runs a simplified transfer engine. Software reaches every register through one 8-bit port addressed by a 4-bit offset. Each channel has a 16-bit current address and a 16-bit remaining count. Each value is moved one byte at a time, and a single byte-pointer flip-flop shared by all channels decides whether an access touches the low or the high half. Counts hold the transfer length minus one, so a fully used channel reads back 0xFFFF.

On the transfer side each channel has a request input. Unmasked channels in normal mode compete under a fixed priority. The winner gets an acknowledge, its current address appears on the address output, and its address and count step at the clock edge. When a count wraps past zero, the channel raises a terminal-count pulse and latches a status flag. A channel in auto-initialise mode then reloads the values software last wrote. A channel in cascade mode bypasses the engine: its acknowledge follows its request while it is unmasked.

Top module: `dma4_regif`

## Requirements
- R1: After reset all four channels are masked, the byte pointer selects the low byte, the controller is enabled, the latched terminal-count flags are zero, and no acknowledge is driven.
- R2: Offset 2n (n = 0..3) accesses channel n's current address and offset 2n+1 its remaining count. Each read or write at offsets 0..7 moves one byte. The low byte goes when the shared pointer is clear and the high byte when it is set, and the pointer toggles after every such access. Reads return data combinationally while the read strobe is high.
- R3: A write to offset 0xC, whatever the data, clears the byte pointer.
- R4: A write to offset 0xA selects a channel with data[1:0] and masks it if data[2] is 1, or unmasks it if data[2] is 0. A write to 0xE unmasks all channels. A write to 0xF loads all four mask bits from data[3:0]. A masked channel is never acknowledged.
- R5: A write to offset 0xB selects a channel with data[1:0] and stores data[7:2] as its mode. The fields are: [7:6] = 11 for cascade, bit 5 for address decrement, bit 4 for auto-initialise, and [3:2] for direction. A cascade channel's acknowledge equals its request while it is unmasked, and its address and count do not change.
- R6: Of the unmasked, non-cascade channels with a request, only the lowest-numbered one is acknowledged, and the address output shows its current address. No such grant is made while data bit 2 of the last write to offset 0x8 is set, or in a cycle in which a read or write strobe is active.
- R7: Each grant increments the channel's address (or decrements it when mode bit 5 is set) and decrements its count, both at the end of the grant cycle.
- R8: A grant made while the count is 0 pulses that channel's terminal-count output in the grant cycle. Without auto-initialise the count becomes 0xFFFF.
- R9: In auto-initialise mode (mode bit 4), a terminal-count grant reloads the address and count with the values last written through the port.
- R10: A read at offset 0x8 returns the latched terminal-count flags in [3:0] and the live request inputs in [7:4], then clears the flags.
- R11: A write to offset 0xD masks all channels, clears the byte pointer, the terminal-count flags and the disable bit. A read at 0xD returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4 | Register offset |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when no read |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge |
| xfer_addr | output | 16 | Current address of the granted channel |
| tc_out | output | 4 | Terminal-count pulse per channel |

## Verification
The assertions check the grant rules on every cycle. An acknowledge needs a request and no mask, at most one non-cascade grant is made, host cycles block grants, and cascade pass-through holds. They also check that terminal count only comes with an acknowledge, and what the pointer-clear, master-clear and status-read strobes leave behind. Some behaviours can only be seen in the bench's scenarios: the byte order of 16-bit accesses, the arithmetic of address and count steps in both directions, the wrap to 0xFFFF, auto-initialise reloads, and which channel wins under fixed priority. The bench's reference model follows these on every clock.

// File: rtl/dma4_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the four-channel DMA register interface.
// Assumes an 8-bit data port and a 4-bit offset space.
package dma4_pkg;

    // Control offsets above the per-channel address/count window
    typedef enum logic [3:0] {
        REG_CMDSTAT   = 4'h8,
        REG_SWREQ     = 4'h9,
        REG_MASK1     = 4'hA,
        REG_MODE      = 4'hB,
        REG_PTRCLR    = 4'hC,
        REG_MCLR      = 4'hD,
        REG_UNMASKALL = 4'hE,
        REG_MASKALL   = 4'hF
    } reg_off_e;

    // Channel mode as held per channel (write data bits [7:2])
    typedef struct packed {
        logic [1:0] sel;       // 2'b11 = cascade pass-through
        logic       dec;       // address decrement
        logic       autoinit;  // reload on terminal count
        logic [1:0] dir;       // transfer direction
    } chan_mode_t;

    localparam logic [1:0] SEL_CASCADE = 2'b11;
    localparam int         CMD_DIS_BIT = 2;
    localparam int         MASK_BIT    = 2;

endpackage

// File: rtl/dma4_byteptr.sv
`timescale 1ns/1ps
// Shared low/high byte pointer for 16-bit accesses over the 8-bit port.
// Assumes clear and toggle are never requested in the same cycle; clear wins.
module dma4_byteptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic toggle,
    output logic hi_sel
);

    // Pointer state: cleared by reset or clear strobe, flips per access
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_sel <= 1'b0;
        else if (clr)    hi_sel <= 1'b0;
        else if (toggle) hi_sel <= ~hi_sel;
    end

endmodule

// File: rtl/dma4_prio_arb.sv
`timescale 1ns/1ps
// Fixed-priority arbiter: lowest index wins, no grant when disabled.
// Assumes req is already filtered for mask and mode.
module dma4_prio_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    input  logic         en,
    output logic [N-1:0] gnt
);

    // Pick the first requesting index
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (en && req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma4_chan.sv
`timescale 1ns/1ps
// One DMA channel: current and base address/count, mode, transfer stepping.
// Assumes host byte writes and a granted transfer never share a cycle; the
// write takes precedence if they do.
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_en,
    input  logic              wr_cnt_en,
    input  logic              hi_sel,
    input  logic [DW-1:0]     wdata,
    input  logic              mode_wr,
    input  chan_mode_t        mode_in,
    input  logic              xfer_en,
    output logic [2*DW-1:0]   cur_addr,
    output logic [2*DW-1:0]   cur_cnt,
    output chan_mode_t        mode_q,
    output logic              tc
);

    localparam int RW = 2 * DW;

    logic [RW-1:0] base_addr;
    logic [RW-1:0] base_cnt;

    assign tc = xfer_en && (cur_cnt == '0);

    // Mode register
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= mode_in;
    end

    // Address: byte write into current and base, else step on transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            base_addr <= '0;
        end else if (wr_addr_en) begin
            if (hi_sel) begin
                cur_addr[RW-1:DW]  <= wdata;
                base_addr[RW-1:DW] <= wdata;
            end else begin
                cur_addr[DW-1:0]   <= wdata;
                base_addr[DW-1:0]  <= wdata;
            end
        end else if (xfer_en) begin
            if (tc && mode_q.autoinit) cur_addr <= base_addr;
            else if (mode_q.dec)       cur_addr <= cur_addr - 1'b1;
            else                       cur_addr <= cur_addr + 1'b1;
        end
    end

    // Count: byte write into current and base, else decrement on transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cnt  <= '0;
            base_cnt <= '0;
        end else if (wr_cnt_en) begin
            if (hi_sel) begin
                cur_cnt[RW-1:DW]  <= wdata;
                base_cnt[RW-1:DW] <= wdata;
            end else begin
                cur_cnt[DW-1:0]   <= wdata;
                base_cnt[DW-1:0]  <= wdata;
            end
        end else if (xfer_en) begin
            if (tc && mode_q.autoinit) cur_cnt <= base_cnt;
            else                       cur_cnt <= cur_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/dma4_regif.sv
`timescale 1ns/1ps
// Four-channel DMA register interface with a simplified transfer engine.
// Assumes at most one of io_wr/io_rd per cycle and DW of at least 8.
module dma4_regif
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int OW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OW-1:0]     io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DW-1:0]     io_wdata,
    output logic [DW-1:0]     io_rdata,
    input  logic [NCH-1:0]    dreq,
    output logic [NCH-1:0]    dack,
    output logic [2*DW-1:0]   xfer_addr,
    output logic [NCH-1:0]    tc_out
);

    localparam int RW = 2 * DW;
    localparam int CW = $clog2(NCH);
    localparam logic [OW-1:0] WIN_END = OW'(2 * NCH);

    logic              host_acc;
    logic              in_window;
    logic [CW-1:0]     ch_sel;
    logic              is_cnt;
    logic              ptr_hi;
    logic              cmd_dis_q;
    logic [NCH-1:0]    mask_q;
    logic [NCH-1:0]    tc_lat_q;
    logic [NCH-1:0]    casc_vec;
    logic [NCH-1:0]    elig;
    logic [NCH-1:0]    gnt;
    logic              wr_mclr;
    logic              rd_stat;
    logic [RW-1:0]     ch_addr [NCH];
    logic [RW-1:0]     ch_cnt  [NCH];
    chan_mode_t        ch_mode [NCH];

    assign host_acc  = io_wr | io_rd;
    assign in_window = io_addr < WIN_END;
    assign ch_sel    = io_addr[CW:1];
    assign is_cnt    = io_addr[0];
    assign wr_mclr   = io_wr && (io_addr == REG_MCLR);
    assign rd_stat   = io_rd && (io_addr == REG_CMDSTAT);

    dma4_byteptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (io_wr && ((io_addr == REG_PTRCLR) || (io_addr == REG_MCLR))),
        .toggle (host_acc && in_window),
        .hi_sel (ptr_hi)
    );

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            logic hit;
            assign hit = io_wr && in_window && (ch_sel == CW'(g));
            dma4_chan #(.DW(DW)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_addr_en (hit && !is_cnt),
                .wr_cnt_en  (hit && is_cnt),
                .hi_sel     (ptr_hi),
                .wdata      (io_wdata),
                .mode_wr    (io_wr && (io_addr == REG_MODE) &&
                             (io_wdata[CW-1:0] == CW'(g))),
                .mode_in    (chan_mode_t'(io_wdata[7:2])),
                .xfer_en    (gnt[g]),
                .cur_addr   (ch_addr[g]),
                .cur_cnt    (ch_cnt[g]),
                .mode_q     (ch_mode[g]),
                .tc         (tc_out[g])
            );
            assign casc_vec[g] = (ch_mode[g].sel == SEL_CASCADE);
        end
    endgenerate

    assign elig = dreq & ~mask_q & ~casc_vec;

    dma4_prio_arb #(.N(NCH)) u_arb (
        .req (elig),
        .en  (!cmd_dis_q && !host_acc),
        .gnt (gnt)
    );

    assign dack = gnt | (dreq & ~mask_q & casc_vec);

    // Address of the granted channel onto the transfer bus
    always_comb begin
        xfer_addr = '0;
        for (int i = 0; i < NCH; i++)
            if (gnt[i]) xfer_addr = xfer_addr | ch_addr[i];
    end

    // Mask bits: master clear, unmask-all, mask-all and single-channel writes
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr)
            mask_q <= '1;
        else if (io_wr && (io_addr == REG_UNMASKALL))
            mask_q <= '0;
        else if (io_wr && (io_addr == REG_MASKALL))
            mask_q <= io_wdata[NCH-1:0];
        else if (io_wr && (io_addr == REG_MASK1))
            mask_q[io_wdata[CW-1:0]] <= io_wdata[MASK_BIT];
    end

    // Controller disable bit from the command register
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr)
            cmd_dis_q <= 1'b0;
        else if (io_wr && (io_addr == REG_CMDSTAT))
            cmd_dis_q <= io_wdata[CMD_DIS_BIT];
    end

    // Terminal-count flags: set by pulses, cleared by status read
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr)
            tc_lat_q <= '0;
        else
            tc_lat_q <= (rd_stat ? '0 : tc_lat_q) | tc_out;
    end

    // Read data mux
    always_comb begin
        logic [RW-1:0] word;
        word     = is_cnt ? ch_cnt[ch_sel] : ch_addr[ch_sel];
        io_rdata = '0;
        if (io_rd) begin
            if (in_window) begin
                io_rdata = ptr_hi ? word[RW-1:DW] : word[DW-1:0];
            end else if (io_addr == REG_CMDSTAT) begin
                io_rdata[NCH-1:0]     = tc_lat_q;
                io_rdata[2*NCH-1:NCH] = dreq;
            end
        end
    end

endmodule

// File: rtl/dma4_regif_chk.sv
`timescale 1ns/1ps
// Property checker for dma4_regif, attached by bind.
module dma4_regif_chk
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int OW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           io_wr,
    input logic           io_rd,
    input logic [OW-1:0]  io_addr,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] dack,
    input logic [NCH-1:0] tc_out,
    input logic [NCH-1:0] mask_q,
    input logic [NCH-1:0] casc_vec,
    input logic           ptr_hi,
    input logic [NCH-1:0] tc_lat_q
);

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dack & ~dreq) == '0);                                   // R6
    AST_MASKED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (dack & mask_q) == '0);                                  // R4
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack & ~casc_vec));                             // R6
    AST_HOST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr || io_rd) |-> ((dack & ~casc_vec) == '0));        // R6
    AST_CASC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (dack & casc_vec) == (dreq & ~mask_q & casc_vec));       // R5
    AST_TC_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_out & ~dack) == '0);                                 // R8
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == REG_PTRCLR) |=> !ptr_hi);           // R3
    AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == REG_MCLR) |=>
        (mask_q == '1 && !ptr_hi && tc_lat_q == '0));            // R11
    AST_STAT_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == REG_CMDSTAT) |=> (tc_lat_q == '0)); // R10

endmodule

bind dma4_regif dma4_regif_chk #(.NCH(NCH), .OW(OW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .dreq     (dreq),
    .dack     (dack),
    .tc_out   (tc_out),
    .mask_q   (mask_q),
    .casc_vec (casc_vec),
    .ptr_hi   (ptr_hi),
    .tc_lat_q (tc_lat_q)
);

// File: tb/dma4_regif_tb.sv
`timescale 1ns/1ps
module dma4_regif_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic [15:0] xfer_addr;
    logic [3:0]  tc_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    dma4_regif dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dreq(dreq), .dack(dack), .xfer_addr(xfer_addr), .tc_out(tc_out)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [15:0] m_addr[4], m_cnt[4], m_baddr[4], m_bcnt[4];
    bit [7:0]  m_mode[4];
    bit        m_mask[4], m_tcl[4];
    bit        m_ptr, m_dis;

    function automatic bit m_casc(int c);
        return m_mode[c][7:6] == 2'b11;
    endfunction

    function automatic int m_grant();
        if (m_dis || io_wr || io_rd) return -1;
        for (int c = 0; c < 4; c++)
            if (dreq[c] && !m_mask[c] && !m_casc(c)) return c;
        return -1;
    endfunction

    function automatic void m_reset();
        for (int c = 0; c < 4; c++) begin
            m_addr[c] = 0; m_cnt[c] = 0; m_baddr[c] = 0; m_bcnt[c] = 0;
            m_mode[c] = 0; m_mask[c] = 1; m_tcl[c] = 0;
        end
        m_ptr = 0; m_dis = 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            int g;
            g = m_grant();
            if (io_rd && io_addr == 4'h8)
                for (int c = 0; c < 4; c++) m_tcl[c] = 0;
            if (g >= 0) begin
                if (m_cnt[g] == 0) begin
                    m_tcl[g] = 1;
                    if (m_mode[g][4]) begin
                        m_addr[g] = m_baddr[g]; m_cnt[g] = m_bcnt[g];
                    end else begin
                        m_addr[g] = m_mode[g][5] ? m_addr[g] - 1 : m_addr[g] + 1;
                        m_cnt[g]  = m_cnt[g] - 1;
                    end
                end else begin
                    m_addr[g] = m_mode[g][5] ? m_addr[g] - 1 : m_addr[g] + 1;
                    m_cnt[g]  = m_cnt[g] - 1;
                end
            end
            if (io_rd && io_addr < 8) m_ptr = !m_ptr;
            if (io_wr) begin
                if (io_addr < 8) begin
                    int c;
                    c = io_addr >> 1;
                    if (io_addr[0]) begin
                        if (m_ptr) begin m_cnt[c][15:8] = io_wdata; m_bcnt[c][15:8] = io_wdata; end
                        else       begin m_cnt[c][7:0]  = io_wdata; m_bcnt[c][7:0]  = io_wdata; end
                    end else begin
                        if (m_ptr) begin m_addr[c][15:8] = io_wdata; m_baddr[c][15:8] = io_wdata; end
                        else       begin m_addr[c][7:0]  = io_wdata; m_baddr[c][7:0]  = io_wdata; end
                    end
                    m_ptr = !m_ptr;
                end else case (io_addr)
                    4'h8: m_dis = io_wdata[2];
                    4'hA: m_mask[io_wdata[1:0]] = io_wdata[2];
                    4'hB: m_mode[io_wdata[1:0]] = {io_wdata[7:2], 2'b00};
                    4'hC: m_ptr = 0;
                    4'hD: begin
                        for (int c = 0; c < 4; c++) begin m_mask[c] = 1; m_tcl[c] = 0; end
                        m_ptr = 0; m_dis = 0;
                    end
                    4'hE: for (int c = 0; c < 4; c++) m_mask[c] = 0;
                    4'hF: for (int c = 0; c < 4; c++) m_mask[c] = io_wdata[c];
                    default: ;
                endcase
            end
        end
    end

    // Compare every output against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int g, ed, ea, et, er;
            g  = m_grant();
            ed = (g >= 0) ? (1 << g) : 0;
            for (int c = 0; c < 4; c++)
                if (dreq[c] && !m_mask[c] && m_casc(c)) ed |= (1 << c);
            ea = (g >= 0) ? m_addr[g] : 0;
            et = (g >= 0 && m_cnt[g] == 0) ? (1 << g) : 0;
            er = 0;
            if (io_rd) begin
                if (io_addr < 8) begin
                    int w;
                    w  = io_addr[0] ? m_cnt[io_addr >> 1] : m_addr[io_addr >> 1];
                    er = m_ptr ? (w >> 8) & 255 : w & 255;
                end else if (io_addr == 4'h8) begin
                    er = dreq << 4;
                    for (int c = 0; c < 4; c++) er |= m_tcl[c] << c;
                end
            end
            check("R6", "model dack", dack, ed);
            check("R7", "model xfer_addr", xfer_addr, ea);
            check("R8", "model tc_out", tc_out, et);
            check("R2", "model io_rdata", io_rdata, er);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1 io_wr = 1; io_addr = a; io_wdata = d;
        @(posedge clk); #1 io_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(posedge clk); #1 io_rd = 1; io_addr = a;
        @(negedge clk); d = io_rdata;
        @(posedge clk); #1 io_rd = 0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input int exp, input string req);
        logic [7:0] d;
        rd(a, d);
        check(req, "read", d, exp);
    endtask

    task automatic req_hold(input logic [3:0] v, input int n);
        @(posedge clk); #1 dreq = v;
        repeat (n) @(posedge clk);
        #1 dreq = 0;
    endtask

    task automatic ack_chk(input logic [3:0] v, input int exp, input string req);
        @(posedge clk); #1 dreq = v;
        @(negedge clk); check(req, "dack", dack, exp);
        @(posedge clk); #1 dreq = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        rd_chk(4'h8, 8'h00, "R1");
        ack_chk(4'hF, 4'h0, "R1");

        // R2: program channel 1 and read back in byte order
        wr(4'hC, 8'h00);
        wr(4'h2, 8'h34); wr(4'h2, 8'h12);
        wr(4'h3, 8'h02); wr(4'h3, 8'h00);
        wr(4'hB, 8'h45);
        wr(4'hA, 8'h01);                       // R4 unmask ch1
        rd_chk(4'h2, 8'h34, "R2"); rd_chk(4'h2, 8'h12, "R2");
        rd_chk(4'h3, 8'h02, "R2"); rd_chk(4'h3, 8'h00, "R2");

        // R3: pointer clear between the halves
        wr(4'h0, 8'hAA); wr(4'hC, 8'h5A);
        wr(4'h0, 8'h55); wr(4'h0, 8'h66);
        rd_chk(4'h0, 8'h55, "R3"); rd_chk(4'h0, 8'h66, "R3");

        // R7/R8: three transfers end in terminal count
        req_hold(4'b0010, 3);
        rd_chk(4'h3, 8'hFF, "R8"); rd_chk(4'h3, 8'hFF, "R8");
        rd_chk(4'h2, 8'h37, "R7"); rd_chk(4'h2, 8'h12, "R7");
        // R10: status then cleared
        rd_chk(4'h8, 8'h02, "R10"); rd_chk(4'h8, 8'h00, "R10");

        // R6: priority ch0 over ch2; ch2 in decrement mode
        wr(4'h4, 8'h00); wr(4'h4, 8'h20);
        wr(4'h5, 8'h0A); wr(4'h5, 8'h00);
        wr(4'hB, 8'h66);
        wr(4'hA, 8'h00); wr(4'hA, 8'h02);
        ack_chk(4'b0101, 4'b0001, "R6");
        req_hold(4'b0100, 2);
        rd_chk(4'h4, 8'hFE, "R7"); rd_chk(4'h4, 8'h1F, "R7");
        rd_chk(4'h8, 8'h01, "R10");

        // R5: cascade pass-through, address untouched
        wr(4'hB, 8'hC3); wr(4'hA, 8'h03);
        ack_chk(4'b1000, 4'b1000, "R5");
        rd_chk(4'h6, 8'h00, "R5"); rd_chk(4'h6, 8'h00, "R5");

        // R9: auto-initialise reload on ch0
        wr(4'h0, 8'h00); wr(4'h0, 8'h01);
        wr(4'h1, 8'h01); wr(4'h1, 8'h00);
        wr(4'hB, 8'h54);
        req_hold(4'b0001, 3);
        rd_chk(4'h0, 8'h01, "R9"); rd_chk(4'h0, 8'h01, "R9");
        rd_chk(4'h1, 8'h00, "R9"); rd_chk(4'h1, 8'h00, "R9");
        rd_chk(4'h8, 8'h01, "R9");

        // R6: controller disable
        wr(4'h8, 8'h04);
        ack_chk(4'b0101, 4'b0000, "R6");
        wr(4'h8, 8'h00);

        // R4: mask-all, unmask-all, single mask
        wr(4'hF, 8'h0F);
        ack_chk(4'b0111, 4'b0000, "R4");
        wr(4'hE, 8'h00);
        ack_chk(4'b0110, 4'b0010, "R4");
        wr(4'hA, 8'h05);
        ack_chk(4'b0110, 4'b0100, "R4");

        // R6: host cycle blocks grant
        @(posedge clk); #1 dreq = 4'b0100; io_wr = 1; io_addr = 4'h9; io_wdata = 8'h00;
        @(negedge clk); check("R6", "dack during host write", dack, 0);
        @(posedge clk); #1 dreq = 0; io_wr = 0;

        // R11: master clear
        req_hold(4'b0001, 1);
        wr(4'h0, 8'h77);
        wr(4'hD, 8'h00);
        rd_chk(4'hD, 8'h00, "R11");
        rd_chk(4'h8, 8'h00, "R11");
        rd_chk(4'h0, 8'h77, "R11");
        ack_chk(4'b0111, 4'b0000, "R11");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule